// File: doc/BRIEF.md
# Dual Timer Clock Prescaler Selector

This block produces the count-enable pulses for two 8-bit timer/counters. It runs entirely on the fast peripheral clock. Inside, it derives a slow core-clock enable that fires once every sixteen fast cycles. Each timer owns a prescaler chain, a select input and a synchronous chain clear. The outputs are single-cycle enable strobes for a counter that sits on the same fast clock. They are never used as derived clocks.

Timer 0 counts only from the core enable. It can be stopped, or it can run from the core enable undivided, from the core enable divided by 8, 64, 256 or 1024, or from one edge of an external pin. Timer 1 can pick among the fast clock undivided, the fast clock divided by 2, 4 or 8, the core rate, and the core rate divided by 2 through 1024. Its chain therefore spans divisions from 1 up to 16384 fast cycles. A write of a timer's clear input restarts that timer's chain, so the next divided strobe lands a known number of cycles later.

Top module: `dual_tmr_prescaler`

## Requirements
- R1: The core enable fires exactly once every 16 fast clock cycles. Timer 0 with select 1 and timer 1 with select 5 each give one strobe per 16 cycles.
- R2: Timer 1 select s in 1..15 gives one strobe every 2^(s-1) fast cycles.
- R3: Timer 0 select 1..5 gives one strobe per 1, 8, 64, 256 and 1024 core enables, and every such strobe coincides with a core enable.
- R4: Select 0 on either timer holds that timer's strobe low.
- R5: The clear input is sampled on a clock edge and zeroes that timer's chain. For timer 1 with select s, the sample taken on the cycle after the clearing edge is cycle 0. The first strobe then comes at cycle 2^(s-1)-1, and no strobe comes at cycle 0 when s is 2 or more.
- R6: Timer 0 select 7 counts rising edges of the external pin and select 6 counts falling edges. The pin passes through two synchronizer flops. Each qualifying edge yields exactly one strobe, seen two edges after the pin changes. An edge of the opposite direction yields none.
- R7: A new select value is registered on the next clock edge and governs the strobe from that cycle on. Timer 1 select 1 produces a strobe on every cycle after it is registered.
- R8: An active-low asynchronous reset clears all state at once and holds both strobes low while it is asserted.
- R9: A divided strobe (timer 1 select 2..15, timer 0 external edge) never lasts two consecutive cycles while the select is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| t0_sel | input | 3 | Timer 0 source select: 0 stop, 1 core, 2..5 core/8,/64,/256,/1024, 6 pin fall, 7 pin rise |
| t0_psc_clr | input | 1 | Synchronous clear of the timer 0 chain |
| t0_ext_pin | input | 1 | Asynchronous external count pin for timer 0 |
| t1_sel | input | 4 | Timer 1 source select: 0 stop, s gives a period of 2^(s-1) fast cycles |
| t1_psc_clr | input | 1 | Synchronous clear of the timer 1 chain |
| t0_tick | output | 1 | Timer 0 count enable, one cycle wide |
| t1_tick | output | 1 | Timer 1 count enable, one cycle wide |

## Verification
The properties assume that the select and clear inputs are driven synchronously to the fast clock. They also assume that a select value is held long enough for its registered copy to matter, because the one-cycle-latency checks compare a port value with the strobe on the following edge. The bench changes every synchronous input on the falling clock edge. It changes the external pin only while the matching select is already registered, so that the synchronizer delay alone sets the pulse timing. Each table vector starts with a clear of both chains. Its window is a multiple of sixteen cycles, which makes the expected pulse counts independent of the free-running core phase.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
  localparam int unsigned TAP_W = 16;

  typedef enum logic [2:0] {
    T0_STOP     = 3'd0,
    T0_CORE     = 3'd1,
    T0_DIV8     = 3'd2,
    T0_DIV64    = 3'd3,
    T0_DIV256   = 3'd4,
    T0_DIV1024  = 3'd5,
    T0_PIN_FALL = 3'd6,
    T0_PIN_RISE = 3'd7
  } t0_src_e;

  // True when the low n bits of cnt are all ones.
  function automatic logic low_ones(input logic [TAP_W-1:0] cnt, input int unsigned n);
    logic [TAP_W-1:0] m;
    m = (TAP_W'(1) << n) - TAP_W'(1);
    return (cnt & m) == m;
  endfunction

  // Divide ratio of timer 0 taps as a power of two of core enables.
  function automatic int unsigned t0_div_log2(input logic [2:0] s);
    case (s)
      T0_DIV8:    return 3;
      T0_DIV64:   return 6;
      T0_DIV256:  return 8;
      T0_DIV1024: return 10;
      default:    return 0;
    endcase
  endfunction

  // Divide ratio of timer 1 taps as a power of two of fast cycles.
  function automatic int unsigned t1_div_log2(input logic [3:0] s);
    return (s == 4'd0) ? 0 : int'(s) - 1;
  endfunction
endpackage

// File: rtl/dtp_base_en.sv
module dtp_base_en #(
  parameter int unsigned RATIO_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic en_o
);
  logic [RATIO_LOG2-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign en_o = &div_q;
endmodule

// File: rtl/dtp_chain.sv
module dtp_chain #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (step_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dtp_edge_sync.sv
module dtp_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/dual_tmr_prescaler.sv
module dual_tmr_prescaler #(
  parameter int unsigned CK_RATIO_LOG2 = 4,
  parameter int unsigned PSC_W         = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] t0_sel,
  input  logic       t0_psc_clr,
  input  logic       t0_ext_pin,
  input  logic [3:0] t1_sel,
  input  logic       t1_psc_clr,
  output logic       t0_tick,
  output logic       t1_tick
);
  import dtp_pkg::*;

  localparam int unsigned T1_W = CK_RATIO_LOG2 + PSC_W;

  // Named internal events for the checker.
  logic             ck_en;
  logic             t0_ext_rise, t0_ext_fall;
  logic [2:0]       t0_sel_q;
  logic [3:0]       t1_sel_q;
  logic [PSC_W-1:0] t0_cnt;
  logic [T1_W-1:0]  t1_cnt;

  dtp_base_en #(.RATIO_LOG2(CK_RATIO_LOG2)) u_core_en (
    .clk(clk), .rst_n(rst_n), .en_o(ck_en)
  );

  dtp_chain #(.W(PSC_W)) u_t0_chain (
    .clk(clk), .rst_n(rst_n), .clr_i(t0_psc_clr), .step_i(ck_en), .cnt_o(t0_cnt)
  );

  dtp_chain #(.W(T1_W)) u_t1_chain (
    .clk(clk), .rst_n(rst_n), .clr_i(t1_psc_clr), .step_i(1'b1), .cnt_o(t1_cnt)
  );

  dtp_edge_sync u_pin_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(t0_ext_pin),
    .rise_o(t0_ext_rise), .fall_o(t0_ext_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t0_sel_q <= '0;
      t1_sel_q <= '0;
    end else begin
      t0_sel_q <= t0_sel;
      t1_sel_q <= t1_sel;
    end
  end

  always_comb begin
    case (t0_src_e'(t0_sel_q))
      T0_STOP:     t0_tick = 1'b0;
      T0_CORE:     t0_tick = ck_en;
      T0_PIN_FALL: t0_tick = t0_ext_fall;
      T0_PIN_RISE: t0_tick = t0_ext_rise;
      default:     t0_tick = ck_en & low_ones(TAP_W'(t0_cnt), t0_div_log2(t0_sel_q));
    endcase
  end

  always_comb begin
    if (t1_sel_q == 4'd0) t1_tick = 1'b0;
    else                  t1_tick = low_ones(TAP_W'(t1_cnt), t1_div_log2(t1_sel_q));
  end
endmodule

// File: rtl/dtp_chk.sv
module dtp_chk #(
  parameter int unsigned CK_RATIO_LOG2 = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ck_en,
  input logic [2:0] t0_sel,
  input logic [2:0] t0_sel_q,
  input logic [3:0] t1_sel,
  input logic [3:0] t1_sel_q,
  input logic       t1_psc_clr,
  input logic       t0_tick,
  input logic       t1_tick
);
  localparam int unsigned RATIO = 1 << CK_RATIO_LOG2;

  logic [CK_RATIO_LOG2:0] gap_q;
  logic                   seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (ck_en) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R1
  core_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_en && seen_q) |-> (gap_q == (CK_RATIO_LOG2+1)'(RATIO - 1)));

  // R3
  t0_core_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_tick && t0_sel_q >= 3'd1 && t0_sel_q <= 3'd5) |-> ck_en);

  // R4
  t1_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_sel == 4'd0) |=> !t1_tick);

  // R4
  t0_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_sel == 3'd0) |=> !t0_tick);

  // R5
  t1_clear_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_psc_clr && t1_sel >= 4'd2) |=> !t1_tick);

  // R7
  t1_fast_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_sel == 4'd1) |=> t1_tick);

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!t0_tick && !t1_tick));

  // R9
  t1_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_tick && t1_sel_q >= 4'd2) |=> !(t1_tick && $stable(t1_sel_q)));

  // R6
  t0_pin_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_tick && t0_sel_q == 3'd7) |=> !(t0_tick && t0_sel_q == 3'd7));
endmodule

bind dual_tmr_prescaler dtp_chk #(.CK_RATIO_LOG2(CK_RATIO_LOG2)) i_dtp_chk (
  .clk(clk), .rst_n(rst_n), .ck_en(ck_en),
  .t0_sel(t0_sel), .t0_sel_q(t0_sel_q),
  .t1_sel(t1_sel), .t1_sel_q(t1_sel_q),
  .t1_psc_clr(t1_psc_clr),
  .t0_tick(t0_tick), .t1_tick(t1_tick)
);

// File: tb/test_dual_tmr_prescaler.sv
`timescale 1ns/1ps
module test_dual_tmr_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] t0_sel = '0;
  logic       t0_psc_clr = 1'b0;
  logic       t0_ext_pin = 1'b0;
  logic [3:0] t1_sel = '0;
  logic       t1_psc_clr = 1'b0;
  logic       t0_tick, t1_tick;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_tmr_prescaler i_dual_tmr_prescaler (
    .clk(clk), .rst_n(rst_n),
    .t0_sel(t0_sel), .t0_psc_clr(t0_psc_clr), .t0_ext_pin(t0_ext_pin),
    .t1_sel(t1_sel), .t1_psc_clr(t1_psc_clr),
    .t0_tick(t0_tick), .t1_tick(t1_tick)
  );

  typedef struct packed {
    logic [2:0]  s0;
    logic [3:0]  s1;
    logic [15:0] win;
    logic [15:0] exp0;
    logic [15:0] exp1;
  } vec_t;

  // Windows are multiples of 16 cycles; counts follow R1, R2, R3, R4.
  localparam vec_t VECS [10] = '{
    '{3'd1, 4'd1,  16'd64,    16'd4,  16'd64},
    '{3'd2, 4'd2,  16'd256,   16'd2,  16'd128},
    '{3'd3, 4'd3,  16'd1024,  16'd1,  16'd256},
    '{3'd0, 4'd4,  16'd128,   16'd0,  16'd16},
    '{3'd1, 4'd5,  16'd256,   16'd16, 16'd16},
    '{3'd2, 4'd6,  16'd512,   16'd4,  16'd16},
    '{3'd4, 4'd10, 16'd4096,  16'd1,  16'd8},
    '{3'd5, 4'd15, 16'd16384, 16'd1,  16'd1},
    '{3'd0, 4'd0,  16'd512,   16'd0,  16'd0},
    '{3'd3, 4'd12, 16'd2048,  16'd2,  16'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int c0, c1;
    #1;
    // R8: outputs low while reset is held
    check("R8 reset t0", int'(t0_tick), 0);
    check("R8 reset t1", int'(t1_tick), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Table walk: clear both chains, then count strobes over the window (R1 R2 R3 R4)
    for (int v = 0; v < 10; v++) begin
      @(negedge clk);
      t0_sel = VECS[v].s0; t1_sel = VECS[v].s1;
      t0_psc_clr = 1'b1; t1_psc_clr = 1'b1;
      @(negedge clk);
      t0_psc_clr = 1'b0; t1_psc_clr = 1'b0;
      c0 = 0; c1 = 0;
      for (int i = 0; i < int'(VECS[v].win); i++) begin
        if (i > 0) @(negedge clk);
        c0 += int'(t0_tick);
        c1 += int'(t1_tick);
      end
      check($sformatf("R3 t0 vec%0d", v), c0, int'(VECS[v].exp0));
      check($sformatf("R2 t1 vec%0d", v), c1, int'(VECS[v].exp1));
    end

    // R5: clear phase for timer 1 at PCK/4, strobe at cycle 3 only
    @(negedge clk);
    t0_sel = 3'd0; t1_sel = 4'd3; t1_psc_clr = 1'b1;
    @(negedge clk);
    t1_psc_clr = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (i > 0) @(negedge clk);
      check($sformatf("R5 phase cycle%0d", i), int'(t1_tick), (i == 3) ? 1 : 0);
    end

    // R4 then R7: stopped, then select 1 acts on the next cycle
    @(negedge clk);
    t1_sel = 4'd0;
    repeat (2) @(negedge clk);
    check("R4 t1 stopped", int'(t1_tick), 0);
    t1_sel = 4'd1;
    check("R7 before edge", int'(t1_tick), 0);
    @(negedge clk);
    check("R7 after edge", int'(t1_tick), 1);

    // R6: rising mode
    t1_sel = 4'd0; t0_sel = 3'd7; t0_ext_pin = 1'b0;
    repeat (4) @(negedge clk);
    t0_ext_pin = 1'b1;
    c0 = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (i == 2) check("R6 rise timing", int'(t0_tick), 1);
      c0 += int'(t0_tick);
    end
    check("R6 rise count", c0, 1);
    t0_ext_pin = 1'b0;
    c0 = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      c0 += int'(t0_tick);
    end
    check("R6 fall ignored in rise mode", c0, 0);

    // R6: falling mode
    t0_sel = 3'd6;
    repeat (3) @(negedge clk);
    t0_ext_pin = 1'b1;
    c0 = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      c0 += int'(t0_tick);
    end
    check("R6 rise ignored in fall mode", c0, 0);
    t0_ext_pin = 1'b0;
    c0 = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      c0 += int'(t0_tick);
    end
    check("R6 fall count", c0, 1);

    // R8: asynchronous reset mid-run
    t0_sel = 3'd0; t1_sel = 4'd1;
    repeat (3) @(negedge clk);
    check("R7 running before reset", int'(t1_tick), 1);
    rst_n = 1'b0;
    #1;
    check("R8 async clear t1", int'(t1_tick), 0);
    check("R8 async clear t0", int'(t0_tick), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    finish_run();
  end
endmodule